// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is a small data cache that sits between a pipeline's load/store port and a slow backing memory. It holds 32 data words as four sets of two ways, each way line four words long. Loads that find their word in the cache complete in the same cycle. Loads that miss stall the requester while a whole four-word line is fetched at a fixed cost of five cycles. The fetched line then lands in the way of that set that was used least recently.

Stores are always passed on to the backing memory in the cycle they are accepted, and they never stall. A store that finds its word cached also updates the cached copy. A store that misses leaves the cache exactly as it was. A running counter adds up the cycles spent waiting on read misses, so software-independent profiling of miss cost can be done at the port.

The requester must hold its request stable while ready is low. Backing memory is modelled as a line-wide read port that is sampled at the end of the fifth stall cycle, plus a word-wide write port.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid, ready is high while no request is pending, the miss-cycle counter is zero, and the first read of any address misses.
- R2: A read whose line is cached returns the word at that address on rd_data_o in the same cycle, with ready_o high.
- R3: The word address splits into offset bits [1:0], set index bits [3:2] and tag bits [15:4]. A read miss holds ready_o low for exactly 5 cycles, starting in the request cycle, and the requested word appears with ready_o high in the 6th cycle.
- R4: A read miss brings in all four words of the line, so later reads of any word of that line hit without stalling.
- R5: The miss-cycle counter grows by exactly 5 for each read miss and does not change on read hits, on writes or while idle.
- R6: Every write is accepted in its request cycle with ready_o high, and in that cycle it drives mem_wr_en_o high with the request's address and data.
- R7: A write that hits updates the cached word, so a following read of that address returns the new data without stalling.
- R8: A write that misses allocates no line and leaves the tags, valid bits and replacement state unchanged; a later read of that address misses.
- R9: On a fill the victim is an invalid way if the set has one, otherwise the least recently used way. Read hits, write hits and fills each mark the way they touch as most recently used.
- R10: A given address is never held in both ways of its set, so at most one way reports a hit.
- R11: Sets are independent: misses and fills in one set never evict a line of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| rd_data_o | output | DATA_W | Load data, valid when ready_o is high on a load |
| ready_o | output | 1 | Request completes this cycle; low means stall |
| miss_cycles_o | output | CNT_W | Accumulated read-miss stall cycles |
| mem_blk_addr_o | output | ADDR_W-OFF_W | Line address being fetched from backing memory |
| mem_blk_data_i | input | DATA_W*4 | Line returned by backing memory, word 0 in the low bits |
| mem_wr_en_o | output | 1 | Store forwarded to backing memory |
| mem_wr_addr_o | output | ADDR_W | Store word address |
| mem_wr_data_o | output | DATA_W | Store data |

## Verification
Load hits and all stores are due in the cycle they are presented. A load miss is due in the sixth cycle after it is presented, after five cycles with ready low. The counter reflects a miss one edge after the miss is seen. The bench changes inputs just after a rising edge and reads outputs on the falling edge. Its monitor counts the low-ready cycles of each request and compares the result, the stall length and the memory write outputs against an expected item queued by the driver. The expected load data comes from the bench's own memory model. The expected stall length comes from the replacement order that R9 and R8 dictate.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_FILL = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/wtc_way.sv
module wtc_way #(
    parameter int unsigned TAG_W  = 12,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [IDX_W-1:0]                   lk_idx_i,
    input  logic [TAG_W-1:0]                   lk_tag_i,
    input  logic [OFF_W-1:0]                   lk_off_i,
    output logic                               hit_o,
    output logic [(1<<IDX_W)-1:0]              vld_o,
    output logic [DATA_W-1:0]                  word_o,
    input  logic                               wr_en_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    input  logic                               fill_en_i,
    input  logic [IDX_W-1:0]                   fill_idx_i,
    input  logic [TAG_W-1:0]                   fill_tag_i,
    input  logic [DATA_W*(1<<OFF_W)-1:0]       fill_blk_i
);
    localparam int unsigned SETS  = 1 << IDX_W;
    localparam int unsigned WORDS = 1 << OFF_W;

    typedef struct packed {
        logic [SETS-1:0]                         vld;
        logic [SETS-1:0][TAG_W-1:0]              tag;
        logic [SETS-1:0][WORDS-1:0][DATA_W-1:0]  dat;
    } way_st_t;

    way_st_t way_q, way_d;

    always_comb begin
        way_d = way_q;
        if (fill_en_i) begin
            way_d.vld[fill_idx_i] = 1'b1;
            way_d.tag[fill_idx_i] = fill_tag_i;
            way_d.dat[fill_idx_i] = fill_blk_i;
        end else if (wr_en_i) begin
            way_d.dat[lk_idx_i][lk_off_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) way_q <= '0;
        else        way_q <= way_d;
    end

    assign hit_o  = way_q.vld[lk_idx_i] && (way_q.tag[lk_idx_i] == lk_tag_i);
    assign vld_o  = way_q.vld;
    assign word_o = way_q.dat[lk_idx_i][lk_off_i];

    // a store may only touch a line that is present in this way
    assert_wr_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> hit_o);
    // a word store never alters the tag of its line
    assert_wr_keeps_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !fill_en_i) |=> $stable(way_q.tag));
    assert_fill_not_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && fill_en_i));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned TAG_W   = 12,
    parameter int unsigned PENALTY = 5,
    parameter int unsigned CNT_W   = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid_i,
    input  logic                                   req_write_i,
    input  logic [IDX_W-1:0]                       idx_i,
    input  logic [TAG_W-1:0]                       tag_i,
    input  logic [NUM_WAYS-1:0]                    hit_i,
    input  logic [NUM_WAYS-1:0][(1<<IDX_W)-1:0]    vld_i,
    output logic                                   ready_o,
    output logic [NUM_WAYS-1:0]                    wr_way_o,
    output logic [NUM_WAYS-1:0]                    fill_way_o,
    output logic [IDX_W-1:0]                       fill_idx_o,
    output logic [TAG_W-1:0]                       fill_tag_o,
    output logic                                   mem_wr_en_o,
    output logic [CNT_W-1:0]                       miss_cnt_o
);
    localparam int unsigned SETS = 1 << IDX_W;
    localparam int unsigned CW   = $clog2(PENALTY + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CW-1:0]     cnt;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [SETS-1:0]   lru;   // per set: index of the least recently used way
        logic [CNT_W-1:0]  miss;
    } ctl_st_t;

    ctl_st_t ctl_q, ctl_d;
    logic    victim;

    always_comb begin
        ctl_d       = ctl_q;
        ready_o     = 1'b1;
        wr_way_o    = '0;
        fill_way_o  = '0;
        mem_wr_en_o = 1'b0;

        victim = ctl_q.lru[ctl_q.idx];
        if (!vld_i[0][ctl_q.idx])      victim = 1'b0;
        else if (!vld_i[1][ctl_q.idx]) victim = 1'b1;

        unique case (ctl_q.st)
            CTL_IDLE: begin
                if (req_valid_i) begin
                    if (req_write_i) begin
                        mem_wr_en_o = 1'b1;
                        wr_way_o    = hit_i;
                        if (|hit_i) ctl_d.lru[idx_i] = hit_i[0];
                    end else if (|hit_i) begin
                        ctl_d.lru[idx_i] = hit_i[0];
                    end else begin
                        ready_o    = 1'b0;
                        ctl_d.st   = CTL_FILL;
                        ctl_d.cnt  = CW'(1);
                        ctl_d.idx  = idx_i;
                        ctl_d.tag  = tag_i;
                        ctl_d.miss = ctl_q.miss + CNT_W'(PENALTY);
                    end
                end
            end
            CTL_FILL: begin
                ready_o = 1'b0;
                if (ctl_q.cnt == CW'(PENALTY - 1)) begin
                    fill_way_o[victim]    = 1'b1;
                    ctl_d.lru[ctl_q.idx]  = ~victim;
                    ctl_d.st              = CTL_IDLE;
                    ctl_d.cnt             = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
            end
            default: ctl_d.st = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fill_idx_o = ctl_q.idx;
    assign fill_tag_o = ctl_q.tag;
    assign miss_cnt_o = ctl_q.miss;

    // checker state: consecutive stalled cycles seen so far
    logic [31:0] stall_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || ready_o) stall_run_q <= '0;
        else                   stall_run_q <= stall_run_q + 32'd1;
    end

    assert_stall_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (stall_run_q < PENALTY));
    assert_stall_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && stall_run_q == 32'(PENALTY - 1)) |=> ready_o);
    assert_miss_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o) + CNT_W'(PENALTY)));
    assert_store_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> ready_o);
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OFF_W   = 2,
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned PENALTY = 5,
    parameter int unsigned CNT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic                          req_write_i,
    input  logic [ADDR_W-1:0]             req_addr_i,
    input  logic [DATA_W-1:0]             req_wdata_i,
    output logic [DATA_W-1:0]             rd_data_o,
    output logic                          ready_o,
    output logic [CNT_W-1:0]              miss_cycles_o,
    output logic [ADDR_W-OFF_W-1:0]       mem_blk_addr_o,
    input  logic [DATA_W*(1<<OFF_W)-1:0]  mem_blk_data_i,
    output logic                          mem_wr_en_o,
    output logic [ADDR_W-1:0]             mem_wr_addr_o,
    output logic [DATA_W-1:0]             mem_wr_data_o
);
    localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned SETS  = 1 << IDX_W;

    logic [OFF_W-1:0]                 lk_off;
    logic [IDX_W-1:0]                 lk_idx;
    logic [TAG_W-1:0]                 lk_tag;
    logic [NUM_WAYS-1:0]              hit;
    logic [NUM_WAYS-1:0][SETS-1:0]    vld;
    logic [NUM_WAYS-1:0][DATA_W-1:0]  word;
    logic [NUM_WAYS-1:0]              wr_way;
    logic [NUM_WAYS-1:0]              fill_way;
    logic [IDX_W-1:0]                 fill_idx;
    logic [TAG_W-1:0]                 fill_tag;

    assign lk_off = req_addr_i[OFF_W-1:0];
    assign lk_idx = req_addr_i[OFF_W +: IDX_W];
    assign lk_tag = req_addr_i[ADDR_W-1 -: TAG_W];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        wtc_way #(
            .TAG_W (TAG_W),
            .IDX_W (IDX_W),
            .OFF_W (OFF_W),
            .DATA_W(DATA_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_idx_i  (lk_idx),
            .lk_tag_i  (lk_tag),
            .lk_off_i  (lk_off),
            .hit_o     (hit[w]),
            .vld_o     (vld[w]),
            .word_o    (word[w]),
            .wr_en_i   (wr_way[w]),
            .wr_data_i (req_wdata_i),
            .fill_en_i (fill_way[w]),
            .fill_idx_i(fill_idx),
            .fill_tag_i(fill_tag),
            .fill_blk_i(mem_blk_data_i)
        );
    end

    wtc_ctrl #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .PENALTY(PENALTY),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .idx_i      (lk_idx),
        .tag_i      (lk_tag),
        .hit_i      (hit),
        .vld_i      (vld),
        .ready_o    (ready_o),
        .wr_way_o   (wr_way),
        .fill_way_o (fill_way),
        .fill_idx_o (fill_idx),
        .fill_tag_o (fill_tag),
        .mem_wr_en_o(mem_wr_en_o),
        .miss_cnt_o (miss_cycles_o)
    );

    always_comb begin
        rd_data_o = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit[w]) rd_data_o = rd_data_o | word[w];
        end
    end

    assign mem_blk_addr_o = {fill_tag, fill_idx};
    assign mem_wr_addr_o  = req_addr_i;
    assign mem_wr_data_o  = req_wdata_i;

    // the two ways are separate instances; a duplicated line would show as two hits
    assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && (|hit) && !(|fill_way) && $past(ready_o)) |-> ready_o);
endmodule

// File: tb/sim_wtc_cache.sv
`timescale 1ns/1ps
module sim_wtc_cache;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int STALL  = 5;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [ADDR_W-1:0]      req_addr = '0;
    logic [DATA_W-1:0]      req_wdata = '0;
    logic [DATA_W-1:0]      rd_data;
    logic                   ready;
    logic [31:0]            miss_cycles;
    logic [ADDR_W-3:0]      mem_blk_addr;
    logic [DATA_W*4-1:0]    mem_blk_data = '0;
    logic                   mem_wr_en;
    logic [ADDR_W-1:0]      mem_wr_addr;
    logic [DATA_W-1:0]      mem_wr_data;

    always #4 clk = ~clk;

    wtc_cache u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_write_i   (req_write),
        .req_addr_i    (req_addr),
        .req_wdata_i   (req_wdata),
        .rd_data_o     (rd_data),
        .ready_o       (ready),
        .miss_cycles_o (miss_cycles),
        .mem_blk_addr_o(mem_blk_addr),
        .mem_blk_data_i(mem_blk_data),
        .mem_wr_en_o   (mem_wr_en),
        .mem_wr_addr_o (mem_wr_addr),
        .mem_wr_data_o (mem_wr_data)
    );

    int total = 0;
    int bad   = 0;
    int exp_misses = 0;

    // backing memory model
    logic [DATA_W-1:0] wmem [int];

    function automatic logic [DATA_W-1:0] mval(input logic [ADDR_W-1:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return 32'hC0DE_0000 | {16'h0, a};
    endfunction

    always @(posedge clk) begin
        if (rst_n && mem_wr_en) wmem[int'(mem_wr_addr)] = mem_wr_data;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++)
            mem_blk_data[i*DATA_W +: DATA_W] <= mval({mem_blk_addr, 2'(i)});
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit                 is_wr;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        int                 stall;
        string              req;
    } exp_t;

    exp_t sb[$];

    // driver: inputs change just after a rising edge
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input int stall, input string req);
        exp_t it;
        it.is_wr = wr;
        it.addr  = a;
        it.data  = wr ? wd : mval(a);
        it.stall = stall;
        it.req   = req;
        sb.push_back(it);
        if (stall != 0) exp_misses++;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        while (!ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk(ready === 1'b1, req, "idle ready", 64'(ready), 64'd1);
        chk(miss_cycles === 32'(exp_misses * STALL), req, "miss counter",
            64'(miss_cycles), 64'(exp_misses * STALL));
        @(posedge clk);
        #1;
    endtask

    // monitor: samples on the falling edge
    int stall_seen = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                if (!ready) begin
                    stall_seen++;
                end else if (sb.size() == 0) begin
                    chk(1'b0, "R6", "unexpected completion", 64'd1, 64'd0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(stall_seen == it.stall, it.req, "stall cycles",
                        64'(stall_seen), 64'(it.stall));
                    if (it.is_wr) begin
                        chk(mem_wr_en === 1'b1, "R6", "mem write enable", 64'(mem_wr_en), 64'd1);
                        chk(mem_wr_addr === it.addr && mem_wr_data === it.data, "R6",
                            "mem write addr/data", {mem_wr_addr, mem_wr_data}, {it.addr, it.data});
                    end else begin
                        chk(rd_data === it.data, it.req, "read data",
                            64'(rd_data), 64'(it.data));
                        chk(mem_wr_en === 1'b0, "R6", "no mem write on read", 64'(mem_wr_en), 64'd0);
                    end
                    stall_seen = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        idle_check("R1");
        access(1'b0, 16'h0010, '0, STALL, "R1");   // cold miss, fills way 0
        access(1'b0, 16'h0013, '0, 0, "R4");       // other word of the line
        access(1'b0, 16'h0010, '0, 0, "R2");
        idle_check("R5");
        access(1'b0, 16'h0020, '0, STALL, "R9");   // set 0, second way (invalid one)
        access(1'b0, 16'h0021, '0, 0, "R4");
        access(1'b0, 16'h0010, '0, 0, "R2");       // tag 2 now least recent
        access(1'b0, 16'h0030, '0, STALL, "R3");   // evicts tag 2
        access(1'b0, 16'h0011, '0, 0, "R9");       // tag 1 survived
        access(1'b0, 16'h0022, '0, STALL, "R9");   // tag 2 gone; evicts tag 3
        access(1'b0, 16'h0032, '0, STALL, "R9");   // tag 3 gone; evicts tag 1
        access(1'b0, 16'h0012, '0, STALL, "R9");   // tag 1 back; evicts tag 2
        idle_check("R5");
        // set 0 holds tags 3 and 1, tag 3 least recent
        access(1'b1, 16'h0012, 32'hA5A5_0001, 0, "R7");   // write hit, tag 1 MRU
        access(1'b0, 16'h0012, '0, 0, "R7");
        access(1'b1, 16'h0040, 32'h5A5A_0004, 0, "R8");   // write miss, no allocation
        idle_check("R8");
        access(1'b0, 16'h0012, '0, 0, "R8");              // tag 1 MRU again
        access(1'b0, 16'h0040, '0, STALL, "R8");          // not allocated; evicts tag 3
        access(1'b0, 16'h0013, '0, 0, "R8");              // tag 1 kept
        access(1'b0, 16'h0033, '0, STALL, "R9");          // tag 3 was evicted
        // set 1 traffic must not disturb set 0 (tags 1 and 3 resident now? tag 4 evicted)
        access(1'b0, 16'h0054, '0, STALL, "R11");
        access(1'b0, 16'h0064, '0, STALL, "R11");
        access(1'b0, 16'h0074, '0, STALL, "R11");
        access(1'b0, 16'h0033, '0, 0, "R11");
        access(1'b1, 16'h0075, 32'h1234_5678, 0, "R6");
        access(1'b0, 16'h0075, '0, 0, "R7");
        idle_check("R5");
        repeat (2) @(posedge clk);
        chk(sb.size() == 0, "R3", "pending items", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule